// File: doc/BRIEF.md
# Nibble-Serial Command Register Slave

This block is the peripheral end of a byte-wide command port through which an external master reaches a bank of internal 8-bit registers. A transfer counts as a command only when a 3-bit select input carries the command code and the write strobe is pulsed while READY is high. Each transfer is either an address byte or a data byte, told apart by bit 7. An address byte picks a register and says whether the master wants to write it or read it. A register write then arrives as two data bytes, each carrying one nibble with the upper nibble first. The register is loaded only when the second nibble has been received.

After every accepted byte the block holds READY low for a fixed number of clocks, which stands for its internal processing time. A read request is a single address byte with the read flag set. When the busy period ends, the block places the register value on the data output and pulls the active-low interrupt low.

Six other interrupt sources share that same line. They are latched at all times, but they cannot drive the line while a read is outstanding. Once the master acknowledges the read response with a read strobe on the command select, they become visible.

Top module: `cmd_reg_slave`

## Requirements
- R1: A byte is accepted only when `wr_stb` is high, `sel` equals 3'b100 and `ready` is high. A strobe with any other `sel` value has no effect on the registers or on `ready`.
- R2: An accepted byte with bit 7 = 1 is an address byte. Bit 6 = 0 makes it a write address and bits 5:0 give the register number.
- R3: An accepted byte with bit 7 = 0 is a data byte. Bits 3:0 carry a nibble and bits 6:4 are ignored. The first data byte after a write address supplies the upper nibble and the second supplies the lower nibble. The register changes only when the second nibble is accepted.
- R4: After a write address, each further pair of data bytes writes the same register again.
- R5: After each accepted byte, `ready` is low for exactly BUSY_CYC clock cycles. Strobes that arrive while `ready` is low are ignored.
- R6: An address byte with bit 6 = 1 requests a read of register bits 5:0. `ready` rises in the same cycle that `dout` shows the register value and `int_n` goes low.
- R7: From an accepted read request until its response is acknowledged, `int_n` reflects only the read. Any `irq_src` bit that is high in a cycle is latched meanwhile.
- R8: A `rd_stb` with `sel` = 3'b100 while a read response is shown removes the response. From the next cycle, `dout` shows {2'b00, latched sources} and `int_n` is low if any source is latched. A `rd_stb` while no read is outstanding clears the latched sources.
- R9: Data bytes that arrive with no write address in force are ignored. A read request also leaves no write address in force.
- R10: An address byte accepted between the two nibbles of a write discards the pending upper nibble.
- R11: After reset, `ready` is high, `int_n` is high, `dout` is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 3 | Port select; 3'b100 addresses the command port |
| wr_stb | input | 1 | Write strobe from the master |
| rd_stb | input | 1 | Read strobe (response acknowledge) |
| din | input | 8 | Command byte from the master |
| irq_src | input | 6 | Other interrupt sources |
| dout | output | 8 | Read data or latched interrupt sources |
| ready | output | 1 | High when the next byte may be sent |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with BUSY_CYC = 2 and the default 6-bit address, so all 64 registers can be targeted. With a two-cycle busy window, the bench can push a second strobe and an interrupt pulse into the gap between a read request and its response, and so exercise the ignored-while-busy rule and the interrupt deferral. A busy length above one also separates the cycle in which `ready` falls from the cycle in which the read data appears, so an off-by-one in the busy counter shows up as a wrong busy count.

// File: rtl/cmd_reg_slave.sv
`timescale 1ns/1ps
module cmd_reg_slave #(
  parameter int AW = 6,
  parameter int BUSY_CYC = 3,
  parameter logic [2:0] SEL_CMD = 3'b100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic [7:0] din,
  input  logic [5:0] irq_src,
  output logic [7:0] dout,
  output logic       ready,
  output logic       int_n
);
  localparam int NREG = 1 << AW;
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] BUSY_LD = CW'(BUSY_CYC);

  logic [7:0]    mem [NREG];
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [3:0]    hi;
  logic          have_addr, half, rd_wait, rd_valid;
  logic [7:0]    rd_data;
  logic [5:0]    irq_lat;

  wire accept = wr_stb && (sel == SEL_CMD) && ready;
  wire rd_ack = rd_stb && (sel == SEL_CMD);

  assign ready = (cnt == '0);
  assign dout  = rd_valid ? rd_data : {2'b00, irq_lat};
  assign int_n = (rd_wait || rd_valid) ? !rd_valid : !(|irq_lat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      addr      <= '0;
      hi        <= '0;
      have_addr <= 1'b0;
      half      <= 1'b0;
      rd_wait   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      irq_lat   <= '0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      if (accept) cnt <= BUSY_LD;
      else if (cnt != '0) cnt <= cnt - 1'b1;

      if (accept && din[7]) begin
        addr      <= din[AW-1:0];
        half      <= 1'b0;
        have_addr <= !din[6];
        rd_wait   <= din[6];
      end else if (accept && have_addr) begin
        if (!half) begin
          hi   <= din[3:0];
          half <= 1'b1;
        end else begin
          mem[addr] <= {hi, din[3:0]};
          half      <= 1'b0;
        end
      end else if (rd_wait && cnt == CW'(1)) begin
        rd_wait <= 1'b0;
        rd_data <= mem[addr];
      end

      if (accept && din[7]) rd_valid <= 1'b0;
      else if (rd_wait && cnt == CW'(1)) rd_valid <= 1'b1;
      else if (rd_ack) rd_valid <= 1'b0;

      if (rd_ack && !rd_valid && !rd_wait) irq_lat <= '0;
      else irq_lat <= irq_lat | irq_src;
    end
  end

  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
  assert_ready_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(accept));
  assert_resp_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (ready && !int_n));
  assert_line_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wait |-> int_n);
  assert_orphan_nibble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !din[7] && !have_addr) |=> !half);
  assert_discard_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && din[7]) |=> !half);
endmodule

// File: tb/test_cmd_reg_slave.sv
`timescale 1ns/1ps
module test_cmd_reg_slave;
  localparam int BUSY = 2;
  logic clk = 0, rst_n = 0;
  logic [2:0] sel = 0;
  logic wr_stb = 0, rd_stb = 0;
  logic [7:0] din = 0;
  logic [5:0] irq_src = 0;
  logic [7:0] dout;
  logic ready, int_n;
  int n_chk = 0, n_bad = 0;
  logic [7:0] model [64];

  cmd_reg_slave #(.AW(6), .BUSY_CYC(BUSY)) i_cmd_reg_slave (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .din(din), .irq_src(irq_src), .dout(dout), .ready(ready), .int_n(int_n));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] addr_byte(input logic rd, input logic [5:0] a);
    return {1'b1, rd, a};
  endfunction
  function automatic logic [7:0] nib_byte(input logic [3:0] n, input logic [2:0] junk);
    return {1'b0, junk, n};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, output int busy);
    while (!ready) @(negedge clk);
    sel = 3'b100; din = b; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0; sel = 0;
    busy = 0;
    while (!ready && busy < 100) begin busy++; @(negedge clk); end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] v);
    int b;
    put(addr_byte(0, a), b);
    put(nib_byte(v[7:4], 3'($urandom)), b);
    put(nib_byte(v[3:0], 3'($urandom)), b);
    model[a] = v;
  endtask

  task automatic rd_check(input logic [5:0] a, input string req);
    int b;
    put(addr_byte(1, a), b);
    chk(b == BUSY, "R5 busy length", b, BUSY);
    chk(!int_n && dout == model[a], req, {int_n, dout}, {1'b0, model[a]});
    sel = 3'b100; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0; sel = 0;
    chk(int_n, "R8 response removed", int_n, 1);
  endtask

  initial begin
    #1000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready && int_n && dout == 0, "R11 reset state", {ready, int_n, dout}, {2'b11, 8'h00});
    rd_check(6'd33, "R11 register zero");

    wr_reg(6'd1, 8'hB0);
    rd_check(6'd1, "R2 R3 R6 write then read");

    put(addr_byte(0, 6'd5), b);
    put(nib_byte(4'hC, 3'b111), b);
    rd_check(6'd5, "R3 single nibble leaves register");

    put(addr_byte(0, 6'd7), b);
    put(nib_byte(4'h1, 3'b101), b); put(nib_byte(4'h2, 3'b010), b);
    put(nib_byte(4'h3, 3'b000), b); put(nib_byte(4'h4, 3'b111), b);
    model[7] = 8'h34;
    rd_check(6'd7, "R4 second pair same register");

    put(nib_byte(4'h9, 3'b000), b); put(nib_byte(4'h9, 3'b000), b);
    rd_check(6'd7, "R9 orphan nibbles ignored");

    put(addr_byte(0, 6'd9), b);
    put(nib_byte(4'hF, 3'b000), b);
    put(addr_byte(0, 6'd10), b);
    put(nib_byte(4'h1, 3'b000), b); put(nib_byte(4'h2, 3'b000), b);
    model[10] = 8'h12;
    rd_check(6'd10, "R10 new address restarts byte");
    rd_check(6'd9, "R10 old target untouched");

    sel = 3'b000; din = addr_byte(0, 6'd12); wr_stb = 1;
    @(negedge clk);
    wr_stb = 0;
    chk(ready, "R1 wrong select keeps ready", ready, 1);
    put(nib_byte(4'h5, 3'b000), b); put(nib_byte(4'h6, 3'b000), b);
    rd_check(6'd12, "R1 wrong select ignored");

    while (!ready) @(negedge clk);
    sel = 3'b100; din = addr_byte(0, 6'd20); wr_stb = 1;
    @(negedge clk);
    din = nib_byte(4'hF, 3'b000);
    @(negedge clk);
    wr_stb = 0; sel = 0;
    while (!ready) @(negedge clk);
    put(nib_byte(4'h3, 3'b000), b); put(nib_byte(4'h4, 3'b000), b);
    model[20] = 8'h34;
    rd_check(6'd20, "R5 strobe while busy ignored");

    while (!ready) @(negedge clk);
    sel = 3'b100; din = addr_byte(1, 6'd1); wr_stb = 1;
    @(negedge clk);
    wr_stb = 0; sel = 0; irq_src = 6'b000100;
    chk(int_n, "R7 line reserved during read", int_n, 1);
    @(negedge clk);
    irq_src = 0;
    chk(int_n, "R7 source deferred", int_n, 1);
    @(negedge clk);
    chk(ready && !int_n && dout == 8'hB0, "R6 response", {ready, int_n, dout}, {2'b10, 8'hB0});
    sel = 3'b100; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0; sel = 0;
    chk(!int_n && dout == 8'h04, "R8 buffered source shown", {int_n, dout}, {1'b0, 8'h04});
    sel = 3'b100; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0; sel = 0;
    chk(int_n && dout == 8'h00, "R8 latch cleared", {int_n, dout}, {1'b1, 8'h00});

    for (int k = 0; k < 150; k++) begin
      logic [5:0] a = 6'($urandom);
      if ($urandom % 2) wr_reg(a, 8'($urandom));
      else rd_check(a, "R3 R6 random traffic");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule